// File: doc/BRIEF.md
# CAN Global Mode Access Guard

This block is the global control and status word of a CAN subsystem with several channels. It holds one global operating-mode bit. That bit decides which parts of the subsystem's address space the host bus may reach. While the mode bit is low, every channel is held in reset. The host may then use the staging (temporary) buffer but not the per-channel registers. While the mode bit is high, the channels run and the host may use their registers, but the staging buffer is locked. The message-buffer window is open in both modes. A pair of lookup registers, one for status and one for starting a lookup, is split by mode as well.

A host access that the current mode does not permit never reaches the downstream region. A blocked read returns zero. A blocked access also produces a one-cycle error interrupt and sets a sticky error flag, which the host clears by writing 1 to it. The guard also enforces the exit interlock. The mode bit falls only after every channel reports its initial state and the shutdown-enable bit has already been set by an earlier write. A write that tries to change both bits at once is rejected. The status word also shows whether the timestamp counter is running.

Top module: `can_gmode_guard`

## Requirements
- R1: After reset the mode bit, the shutdown-enable bit, the sticky error flag, `h_rdata`, `h_rvalid` and `err_irq` are all 0, and every bit of `ch_rst` is 1.
- R2: Every bit of `ch_rst` equals the inverse of `gmode` at all times.
- R3: Region code 1 (address bits [AW-1:AW-3]) selects the channel registers, and channel number = offset bits [AW-4 : AW-3-CH_W]. These registers are reachable only while `gmode`=1. There, `dn_sel[0]` and the one-hot `dn_ch_sel` bit of the addressed channel are asserted in the request cycle.
- R4: Region code 2 (staging buffer, `dn_sel[1]`) is reachable only while `gmode`=0.
- R5: Region code 3 (message buffers, `dn_sel[2]`) is reachable in both modes.
- R6: Region code 4 (lookup status, `dn_sel[3]`) accepts reads in both modes and writes only while `gmode`=0. Region code 5 (lookup start, `dn_sel[4]`) accepts reads in both modes and writes only while `gmode`=1.
- R7: A write to region code 0 (global word) with bit 0 = 1, and without a conflict as in R9, sets `gmode` on the next cycle. Bit 1 of the same write becomes the shutdown-enable bit.
- R8: A global write with bit 0 = 0, while `gmode`=1, clears `gmode` only if the stored shutdown-enable bit was already 1 and all `ch_init` inputs are 1. Otherwise `gmode` stays 1.
- R9: A global write in which bit 0 differs from the current mode bit and bit 1 differs from the current shutdown-enable bit leaves both bits unchanged and raises the error.
- R10: A blocked access, or a conflicting global write, pulses `err_irq` for one cycle on the cycle after the request and sets `err_flag`. A global write with bit 8 = 1 clears `err_flag`, but a set in the same cycle wins.
- R11: A read pulses `h_rvalid` on the next cycle, with `h_rdata` valid in that cycle. A global read returns: bit 0 mode, bit 1 shutdown enable, bit 2 `ts_run`, bit 3 AND of all `ch_init`, bit 8 `err_flag`, and all other bits 0. Blocked reads return 0.
- R12: A permitted access to a downstream region drives exactly one `dn_sel` bit in the request cycle, with `dn_addr` equal to the low AW-3 address bits. A read of that region returns `dn_rdata` as sampled in the request cycle.
- R13: Region codes 6 and 7 are blocked for reads and writes in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_req | input | 1 | Host access request, one cycle per access |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_addr | input | AW | Host address, top three bits select the region |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Read data, valid while h_rvalid is high |
| h_rvalid | output | 1 | Read response strobe, one cycle after the request |
| dn_sel | output | 5 | One-hot downstream region select (channel, staging, message, lookup status, lookup start) |
| dn_ch_sel | output | NUM_CH | One-hot channel select for the channel region |
| dn_wr | output | 1 | Write strobe qualifier towards downstream |
| dn_addr | output | AW-3 | Offset within the region |
| dn_wdata | output | DW | Write data towards downstream |
| dn_rdata | input | DW | Read data from the selected region, same cycle |
| ch_init | input | NUM_CH | Per-channel initial-state flags |
| ts_run | input | 1 | Timestamp counter running |
| ch_rst | output | NUM_CH | Per-channel reset hold |
| gmode | output | 1 | Global mode bit |
| err_irq | output | 1 | Access-error interrupt pulse |
| err_flag | output | 1 | Sticky access-error flag |

## Verification
The downstream selects, the offset and the write data are combinational. The bench checks them shortly after it drives a request, inside the same cycle. Everything else passes through one register: read data, the read strobe, the error pulse, the sticky flag and the mode bit. The bench checks those one falling edge after the request, against a model it updates at that point. The status word is modelled from the state before the access. Each permission case is swept over every region code and both access directions, in both modes.

// File: rtl/can_gmode_pkg.sv
package can_gmode_pkg;

    typedef enum logic [2:0] {
        RG_GLOB   = 3'd0,
        RG_CHREG  = 3'd1,
        RG_STAGE  = 3'd2,
        RG_MSGB   = 3'd3,
        RG_LKSTAT = 3'd4,
        RG_LKGO   = 3'd5,
        RG_RSV6   = 3'd6,
        RG_RSV7   = 3'd7
    } region_e;

    localparam int NUM_DN = 5;

    localparam int GB_MODE    = 0;
    localparam int GB_SHD     = 1;
    localparam int GB_TSRUN   = 2;
    localparam int GB_ALLINIT = 3;
    localparam int GB_ERR     = 8;

endpackage

// File: rtl/can_gmode_decode.sv
module can_gmode_decode
    import can_gmode_pkg::*;
#(
    parameter int AW     = 12,
    parameter int NUM_CH = 4,
    parameter int OFF_W  = AW - 3,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [AW-1:0]    addr,
    output region_e          region,
    output logic [OFF_W-1:0] offset,
    output logic [CH_W-1:0]  ch_idx,
    output logic             ch_valid
);

    always_comb begin
        region   = region_e'(addr[AW-1 -: 3]);
        offset   = addr[OFF_W-1:0];
        ch_idx   = addr[OFF_W-1 -: CH_W];
        ch_valid = (int'(ch_idx) < NUM_CH);
    end

endmodule

// File: rtl/can_gmode_perm.sv
module can_gmode_perm
    import can_gmode_pkg::*;
(
    input  logic              req,
    input  logic              wr,
    input  logic              mode,
    input  region_e           region,
    input  logic              ch_valid,
    output logic              allow,
    output logic [NUM_DN-1:0] sel
);

    always_comb begin
        unique case (region)
            RG_GLOB:   allow = 1'b1;
            RG_CHREG:  allow = mode && ch_valid;
            RG_STAGE:  allow = !mode;
            RG_MSGB:   allow = 1'b1;
            RG_LKSTAT: allow = !(wr && mode);
            RG_LKGO:   allow = !(wr && !mode);
            default:   allow = 1'b0;
        endcase
    end

    for (genvar i = 0; i < NUM_DN; i++) begin : g_sel
        assign sel[i] = req && allow && (region == region_e'(i + 1));
    end

endmodule

// File: rtl/can_gmode_glob.sv
module can_gmode_glob (
    input  logic mode_q,
    input  logic shd_q,
    input  logic all_init,
    input  logic wr_mode,
    input  logic wr_shd,
    output logic mode_nx,
    output logic shd_nx,
    output logic conflict
);

    logic may_leave;

    always_comb begin
        may_leave = mode_q && shd_q && all_init;
        conflict  = (wr_mode != mode_q) && (wr_shd != shd_q);
        shd_nx    = wr_shd;
        if (wr_mode) begin
            mode_nx = 1'b1;
        end else if (may_leave) begin
            mode_nx = 1'b0;
        end else begin
            mode_nx = mode_q;
        end
    end

endmodule

// File: rtl/can_gmode_guard.sv
module can_gmode_guard
    import can_gmode_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int AW     = 12,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_req,
    input  logic              h_wr,
    input  logic [AW-1:0]     h_addr,
    input  logic [DW-1:0]     h_wdata,
    output logic [DW-1:0]     h_rdata,
    output logic              h_rvalid,
    output logic [4:0]        dn_sel,
    output logic [NUM_CH-1:0] dn_ch_sel,
    output logic              dn_wr,
    output logic [AW-4:0]     dn_addr,
    output logic [DW-1:0]     dn_wdata,
    input  logic [DW-1:0]     dn_rdata,
    input  logic [NUM_CH-1:0] ch_init,
    input  logic              ts_run,
    output logic [NUM_CH-1:0] ch_rst,
    output logic              gmode,
    output logic              err_irq,
    output logic              err_flag
);

    localparam int OFF_W = AW - 3;
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic          mode;
        logic          shd;
        logic          err_flag;
        logic          err_pulse;
        logic          rvalid;
        logic [DW-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    region_e           region;
    logic [OFF_W-1:0]  offset;
    logic [CH_W-1:0]   ch_idx;
    logic              ch_valid;
    logic              allow;
    logic [NUM_DN-1:0] sel;
    logic              all_init;
    logic              mode_nx;
    logic              shd_nx;
    logic              conflict;
    logic              glob_wr;
    logic              err_set;
    logic [DW-1:0]     status_word;

    can_gmode_decode #(
        .AW     (AW),
        .NUM_CH (NUM_CH),
        .OFF_W  (OFF_W),
        .CH_W   (CH_W)
    ) i_decode (
        .addr     (h_addr),
        .region   (region),
        .offset   (offset),
        .ch_idx   (ch_idx),
        .ch_valid (ch_valid)
    );

    can_gmode_perm i_perm (
        .req      (h_req),
        .wr       (h_wr),
        .mode     (st_q.mode),
        .region   (region),
        .ch_valid (ch_valid),
        .allow    (allow),
        .sel      (sel)
    );

    can_gmode_glob i_glob (
        .mode_q   (st_q.mode),
        .shd_q    (st_q.shd),
        .all_init (all_init),
        .wr_mode  (h_wdata[GB_MODE]),
        .wr_shd   (h_wdata[GB_SHD]),
        .mode_nx  (mode_nx),
        .shd_nx   (shd_nx),
        .conflict (conflict)
    );

    always_comb begin
        all_init                = &ch_init;
        status_word             = '0;
        status_word[GB_MODE]    = st_q.mode;
        status_word[GB_SHD]     = st_q.shd;
        status_word[GB_TSRUN]   = ts_run;
        status_word[GB_ALLINIT] = all_init;
        status_word[GB_ERR]     = st_q.err_flag;
    end

    always_comb begin
        st_d           = st_q;
        st_d.err_pulse = 1'b0;
        st_d.rvalid    = 1'b0;
        st_d.rdata     = '0;

        glob_wr = h_req && h_wr && (region == RG_GLOB);
        err_set = (h_req && !allow) || (glob_wr && conflict);

        if (h_req && !h_wr) begin
            st_d.rvalid = 1'b1;
            if (allow) begin
                st_d.rdata = (region == RG_GLOB) ? status_word : dn_rdata;
            end
        end

        if (glob_wr && !conflict) begin
            st_d.mode = mode_nx;
            st_d.shd  = shd_nx;
        end

        st_d.err_pulse = err_set;
        if (err_set) begin
            st_d.err_flag = 1'b1;
        end else if (glob_wr && h_wdata[GB_ERR]) begin
            st_d.err_flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_rst[c]    = ~st_q.mode;
        assign dn_ch_sel[c] = sel[0] && (ch_idx == CH_W'(c));
    end

    assign dn_sel   = sel;
    assign dn_wr    = h_wr;
    assign dn_addr  = offset;
    assign dn_wdata = h_wdata;
    assign h_rdata  = st_q.rdata;
    assign h_rvalid = st_q.rvalid;
    assign gmode    = st_q.mode;
    assign err_irq  = st_q.err_pulse;
    assign err_flag = st_q.err_flag;

endmodule

// File: rtl/can_gmode_guard_chk.sv
module can_gmode_guard_chk #(
    parameter int NUM_CH = 4,
    parameter int AW     = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_req,
    input logic              h_wr,
    input logic [AW-1:0]     h_addr,
    input logic [4:0]        dn_sel,
    input logic [NUM_CH-1:0] ch_init,
    input logic [NUM_CH-1:0] ch_rst,
    input logic              gmode,
    input logic              shd_q,
    input logic              h_rvalid,
    input logic              err_irq,
    input logic              err_flag
);

    AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n) !gmode |-> (&ch_rst)); // R2
    AST_RST_FREE: assert property (@(posedge clk) disable iff (!rst_n) gmode |-> (ch_rst == '0)); // R2
    AST_CHREG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) !gmode |-> !dn_sel[0]); // R3
    AST_STAGE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) gmode |-> !dn_sel[1]); // R4
    AST_MSGB_OPEN: assert property (@(posedge clk) disable iff (!rst_n) (h_req && h_addr[AW-1 -: 3] == 3'd3) |-> dn_sel[2]); // R5
    AST_LKGO_WR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) (!gmode && h_wr) |-> !dn_sel[4]); // R6
    AST_LKSTAT_WR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) (gmode && h_wr) |-> !dn_sel[3]); // R6
    AST_LEAVE_INTERLOCK: assert property (@(posedge clk) disable iff (!rst_n) $fell(gmode) |-> ($past(&ch_init) && $past(shd_q))); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err_irq |-> err_flag); // R10
    AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) h_rvalid |-> $past(h_req && !h_wr)); // R11
    AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dn_sel)); // R12
    AST_RSV_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) (h_addr[AW-1 -: 2] == 2'b11) |-> (dn_sel == '0)); // R13

endmodule

bind can_gmode_guard can_gmode_guard_chk #(
    .NUM_CH (NUM_CH),
    .AW     (AW)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .h_req    (h_req),
    .h_wr     (h_wr),
    .h_addr   (h_addr),
    .dn_sel   (dn_sel),
    .ch_init  (ch_init),
    .ch_rst   (ch_rst),
    .gmode    (gmode),
    .shd_q    (st_q.shd),
    .h_rvalid (h_rvalid),
    .err_irq  (err_irq),
    .err_flag (err_flag)
);

// File: tb/test_can_gmode_guard.sv
module test_can_gmode_guard;

    localparam int NUM_CH = 4;
    localparam int AW     = 12;
    localparam int DW     = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              h_req = 1'b0;
    logic              h_wr = 1'b0;
    logic [AW-1:0]     h_addr = '0;
    logic [DW-1:0]     h_wdata = '0;
    logic [DW-1:0]     h_rdata;
    logic              h_rvalid;
    logic [4:0]        dn_sel;
    logic [NUM_CH-1:0] dn_ch_sel;
    logic              dn_wr;
    logic [AW-4:0]     dn_addr;
    logic [DW-1:0]     dn_wdata;
    logic [DW-1:0]     dn_rdata;
    logic [NUM_CH-1:0] ch_init = '0;
    logic              ts_run = 1'b0;
    logic [NUM_CH-1:0] ch_rst;
    logic              gmode;
    logic              err_irq;
    logic              err_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic m_mode = 1'b0;
    logic m_shd  = 1'b0;
    logic m_err  = 1'b0;

    always #2.5 clk = ~clk;

    assign dn_rdata = 32'h5A00_0000 ^ {23'd0, dn_addr};

    can_gmode_guard #(
        .NUM_CH (NUM_CH),
        .AW     (AW),
        .DW     (DW)
    ) i_can_gmode_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .h_req     (h_req),
        .h_wr      (h_wr),
        .h_addr    (h_addr),
        .h_wdata   (h_wdata),
        .h_rdata   (h_rdata),
        .h_rvalid  (h_rvalid),
        .dn_sel    (dn_sel),
        .dn_ch_sel (dn_ch_sel),
        .dn_wr     (dn_wr),
        .dn_addr   (dn_addr),
        .dn_wdata  (dn_wdata),
        .dn_rdata  (dn_rdata),
        .ch_init   (ch_init),
        .ts_run    (ts_run),
        .ch_rst    (ch_rst),
        .gmode     (gmode),
        .err_irq   (err_irq),
        .err_flag  (err_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit permitted(input logic mode, input logic wr, input logic [2:0] rg);
        case (rg)
            3'd0: return 1'b1;
            3'd1: return mode;
            3'd2: return !mode;
            3'd3: return 1'b1;
            3'd4: return !(wr && mode);
            3'd5: return !(wr && !mode);
            default: return 1'b0;
        endcase
    endfunction

    task automatic acc(input logic wr, input logic [2:0] rg, input logic [8:0] off,
                       input logic [31:0] wd, input string req);
        bit            ok;
        logic [4:0]    exp_sel;
        logic [3:0]    exp_ch;
        logic [31:0]   exp_rd;
        logic [31:0]   sw;
        bit            conf;
        bit            err;
        ok      = permitted(m_mode, wr, rg);
        exp_sel = (ok && rg >= 3'd1 && rg <= 3'd5) ? (5'd1 << (rg - 3'd1)) : 5'd0;
        exp_ch  = (ok && rg == 3'd1) ? (4'd1 << off[8:7]) : 4'd0;
        sw      = '0;
        sw[0]   = m_mode;
        sw[1]   = m_shd;
        sw[2]   = ts_run;
        sw[3]   = &ch_init;
        sw[8]   = m_err;
        exp_rd  = (!ok || wr) ? 32'd0 : (rg == 3'd0) ? sw : (32'h5A00_0000 ^ {23'd0, off});
        conf    = wr && rg == 3'd0 && (wd[0] != m_mode) && (wd[1] != m_shd);
        err     = !ok || conf;

        @(negedge clk);
        h_req   = 1'b1;
        h_wr    = wr;
        h_addr  = {rg, off};
        h_wdata = wd;
        #1;
        chk(dn_sel == exp_sel, {req, " R3/R4/R5/R6/R13 dn_sel"}, 32'(dn_sel), 32'(exp_sel));
        chk(dn_ch_sel == exp_ch, {req, " R3 dn_ch_sel"}, 32'(dn_ch_sel), 32'(exp_ch));
        if (exp_sel != 0) begin
            chk(dn_addr == off && dn_wr == wr && dn_wdata == wd, {req, " R12 forward"},
                32'(dn_addr), 32'(off));
        end

        if (wr && rg == 3'd0 && !conf) begin
            if (wd[0]) m_mode = 1'b1;
            else if (m_mode && m_shd && (&ch_init)) m_mode = 1'b0;
            m_shd = wd[1];
        end
        if (err) m_err = 1'b1;
        else if (wr && rg == 3'd0 && wd[8]) m_err = 1'b0;

        @(negedge clk);
        h_req = 1'b0;
        h_wr  = 1'b0;
        chk(err_irq == err, {req, " R10 err_irq"}, 32'(err_irq), 32'(err));
        chk(err_flag == m_err, {req, " R10 err_flag"}, 32'(err_flag), 32'(m_err));
        chk(h_rvalid == !wr, {req, " R11 rvalid"}, 32'(h_rvalid), 32'(!wr));
        chk(h_rdata == exp_rd, {req, " R11/R12 rdata"}, h_rdata, exp_rd);
        chk(gmode == m_mode, {req, " R7/R8/R9 gmode"}, 32'(gmode), 32'(m_mode));
        chk(ch_rst == {NUM_CH{~m_mode}}, {req, " R2 ch_rst"}, 32'(ch_rst), 32'({NUM_CH{~m_mode}}));
    endtask

    task automatic sweep(input logic [31:0] pat, input string req);
        for (int rg = 1; rg < 8; rg++) begin
            for (int w = 0; w < 2; w++) begin
                acc(w[0], rg[2:0], {rg[1:0], 7'h2B ^ pat[6:0]}, pat ^ 32'(rg), req);
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(gmode == 1'b0 && err_flag == 1'b0 && err_irq == 1'b0, "R1 reset flags", 32'(gmode), 0);
        chk(h_rdata == '0 && h_rvalid == 1'b0, "R1 reset read port", h_rdata, 0);
        chk(ch_rst == 4'hF, "R1 reset holds channels", 32'(ch_rst), 32'hF);
        rst_n = 1'b1;
        @(negedge clk);

        acc(1'b0, 3'd0, 9'd0, 0, "R1 R11 status after reset");
        sweep(32'h0000_0011, "R4 sweep mode0");

        acc(1'b1, 3'd0, 9'd0, 32'h0000_0001, "R7 enter mode");
        sweep(32'h0000_0F06, "R3 sweep mode1");

        acc(1'b1, 3'd0, 9'd0, 32'h0000_0002, "R9 both bits change");
        acc(1'b1, 3'd0, 9'd0, 32'h0000_0100, "R10 clear sticky");
        acc(1'b0, 3'd0, 9'd0, 0, "R11 status mode1");

        ch_init = 4'hF;
        acc(1'b1, 3'd0, 9'd0, 32'h0000_0000, "R8 clear without shutdown");
        acc(1'b1, 3'd0, 9'd0, 32'h0000_0003, "R8 arm shutdown");
        ch_init = 4'h7;
        acc(1'b1, 3'd0, 9'd0, 32'h0000_0002, "R8 clear with channel busy");
        ts_run = 1'b1;
        acc(1'b0, 3'd0, 9'd0, 0, "R11 status ts_run");
        ch_init = 4'hF;
        acc(1'b1, 3'd0, 9'd0, 32'h0000_0002, "R8 legal clear");
        acc(1'b0, 3'd1, 9'h180, 0, "R3 channel read after leave");
        acc(1'b1, 3'd0, 9'd0, 32'h0000_0101, "R10 set wins over clear");
        acc(1'b1, 3'd0, 9'd0, 32'h0000_0102, "R10 clear sticky mode0");

        sweep(32'hA5A5_0077, "R6 sweep mode0 again");
        acc(1'b1, 3'd0, 9'd0, 32'h0000_0003, "R7 re-enter mode");
        sweep(32'h1234_0055, "R5 sweep mode1 again");
        for (int c = 0; c < NUM_CH; c++) begin
            acc(1'b1, 3'd1, {c[1:0], 7'h01}, 32'(c), "R3 each channel");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule